// File: doc/BRIEF.md
# Supply Fault Event Monitor

This block watches two power rails through comparator outputs that have already been turned into digital signals. The first rail is the logic rail and the second is the main rail. The block reports each fault condition in two ways. A live status bit follows the comparator in the same cycle. A sticky event bit stays latched until the host clears it by writing a one to that bit.

The main rail has three fault conditions:

- an undervoltage-lockout condition;
- an undervoltage condition, whose comparator is chosen by a 24 V mode input (the high level near 17.5 V, or the low level near 7 V);
- an overvoltage condition, whose trip level is chosen by a registered 2-bit code that the block drives back to the analog comparator (32 V, 34 V or 36 V).

Supply spikes must not record events. Each main-rail event is therefore latched only after its condition has held for a parameterised number of clock cycles, about 10 µs of system clock. The logic-rail lockout event has no such filter.

While the overvoltage status is high, a driver-disable output forces the line drivers off. All pins are plain control and status signals, so no handshake is involved.

Top module: `supply_fault_monitor`

## Requirements
- R1: After reset, all four event bits are 0 and the threshold-select output is 2'b00.
- R2: The status bus follows the comparators in the same cycle, with no register in the path. Bit 0 is the logic-rail lockout, bit 1 the main-rail lockout, bit 2 the main-rail undervoltage and bit 3 the main-rail overvoltage. The event bus uses the same bit order.
- R3: Status bit 2 takes the 17.5 V comparator input when the 24 V mode input is 1, and the 7 V comparator input when it is 0.
- R4: An event bit for a main-rail condition (bits 1 to 3) becomes 1 just after the rising edge that completes FILT_CYCLES consecutive edges at which that condition was sampled true.
- R5: If the condition is sampled false before the count completes, the count starts again from zero.
- R6: The logic-rail lockout event (bit 0) becomes 1 after the first edge at which its condition is sampled true.
- R7: An event bit stays at 1 until the edge at which clr_we is 1 and the matching clr_mask bit is 1. It then reads 0, unless R8 applies. A clr_mask bit of 0 leaves its event bit unchanged.
- R8: If a clear and a new qualified event for the same bit arrive at the same edge, the bit stays 1.
- R9: On an edge with thr_we = 1, the threshold-select output loads a new value from thr_wdata. Code 00 gives 00 (32 V), 01 gives 01 (34 V), and 10 or 11 gives 10 (36 V). The output never reads 11 and holds its value at other times.
- R10: drv_disable is 1 exactly when status bit 3 (overvoltage) is 1, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| vl_below_uvlo | input | 1 | Logic rail below its lockout level (about 2 V) |
| main_below_uvlo | input | 1 | Main rail below its lockout level (about 6 V) |
| main_below_uv7 | input | 1 | Main rail below the low undervoltage level (about 7 V) |
| main_below_uv17 | input | 1 | Main rail below the high undervoltage level (about 17.5 V) |
| mode_24v | input | 1 | Selects the high undervoltage level |
| main_above_ov | input | 1 | Main rail above the selected overvoltage level |
| thr_we | input | 1 | Write strobe for the threshold code |
| thr_wdata | input | 2 | New overvoltage threshold code |
| clr_we | input | 1 | Write strobe for event clearing |
| clr_mask | input | 4 | Write-one-to-clear mask, in event bit order |
| ov_thr_sel | output | 2 | Threshold select sent to the overvoltage comparator |
| live_status | output | 4 | Unfiltered status bits |
| sticky_event | output | 4 | Latched event bits |
| drv_disable | output | 1 | Forces the line drivers off |

## Verification
Two cases are hardest to reach from the ports.

- **Clear and qualify at the same edge.** A clear must land on exactly the edge where a filter completes its count. The stimulus holds conditions for long random stretches while random clear masks arrive, so clears regularly meet conditions that qualify again at once.
- **Glitches one cycle short of the window.** These check that the filter restarts. The stimulus mixes short bursts with long holds, and a reference model counts consecutive samples on every clock.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
  localparam int NUM_EVT   = 4;
  localparam int IDX_VL    = 0;
  localparam int IDX_MUVLO = 1;
  localparam int IDX_MUV   = 2;
  localparam int IDX_MOV   = 3;

  typedef enum logic [1:0] {
    THR_32V = 2'b00,
    THR_34V = 2'b01,
    THR_36V = 2'b10
  } ov_thr_e;

  function automatic ov_thr_e thr_decode(input logic [1:0] code);
    if (code[1])      return THR_36V;
    else if (code[0]) return THR_34V;
    else              return THR_32V;
  endfunction
endpackage

// File: rtl/sfm_qual_filter.sv
module sfm_qual_filter #(
  parameter int FILT_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic qual
);
  localparam int CW = (FILT_CYCLES > 2) ? $clog2(FILT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (!raw)        cnt <= '0;
    else if (cnt != LAST) cnt <= cnt + 1'b1;
  end

  assign qual = raw && (cnt == LAST);

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R4
  AST_FILT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !raw |=> (cnt == '0)); // R5
  AST_QUAL_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
    qual |-> $past(raw)); // R4
endmodule

// File: rtl/sfm_event_bank.sv
module sfm_event_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  output logic [N-1:0] evt_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic clr_hit;
    assign clr_hit = clr_we && clr_mask[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) evt_o[i] <= 1'b0;
      else        evt_o[i] <= (evt_o[i] && !clr_hit) || set_i[i];
    end

    AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_o[i] && !clr_hit) |=> evt_o[i]); // R7
    AST_EVT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit && !set_i[i]) |=> !evt_o[i]); // R7
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> evt_o[i]); // R8
  end
endmodule

// File: rtl/supply_fault_monitor.sv
module supply_fault_monitor
  import sfm_pkg::*;
#(
  parameter int FILT_CYCLES = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vl_below_uvlo,
  input  logic       main_below_uvlo,
  input  logic       main_below_uv7,
  input  logic       main_below_uv17,
  input  logic       mode_24v,
  input  logic       main_above_ov,
  input  logic       thr_we,
  input  logic [1:0] thr_wdata,
  input  logic       clr_we,
  input  logic [3:0] clr_mask,
  output logic [1:0] ov_thr_sel,
  output logic [3:0] live_status,
  output logic [3:0] sticky_event,
  output logic       drv_disable
);
  logic [NUM_EVT-1:0] set_vec;
  ov_thr_e            thr_q;

  always_comb begin
    live_status[IDX_VL]    = vl_below_uvlo;
    live_status[IDX_MUVLO] = main_below_uvlo;
    live_status[IDX_MUV]   = mode_24v ? main_below_uv17 : main_below_uv7;
    live_status[IDX_MOV]   = main_above_ov;
  end

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_chan
    if (i == IDX_VL) begin : g_direct
      assign set_vec[i] = live_status[i];
    end else begin : g_filt
      sfm_qual_filter #(.FILT_CYCLES(FILT_CYCLES)) u_filt (
        .clk  (clk),
        .rst_n(rst_n),
        .raw  (live_status[i]),
        .qual (set_vec[i])
      );
    end
  end

  sfm_event_bank #(.N(NUM_EVT)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_i   (set_vec),
    .clr_we  (clr_we),
    .clr_mask(clr_mask),
    .evt_o   (sticky_event)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      thr_q <= THR_32V;
    else if (thr_we) thr_q <= thr_decode(thr_wdata);
  end

  assign ov_thr_sel  = thr_q;
  assign drv_disable = live_status[IDX_MOV];

  AST_THR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ov_thr_sel != 2'b11); // R9
  AST_THR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !thr_we |=> $stable(ov_thr_sel)); // R9
  AST_DISABLE_ON_OV: assert property (@(posedge clk) disable iff (!rst_n)
    main_above_ov |-> drv_disable); // R10
  AST_VL_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    vl_below_uvlo |=> sticky_event[IDX_VL]); // R6
endmodule

// File: tb/supply_fault_monitor_bench.sv
module supply_fault_monitor_bench;
  localparam int N = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       vl_below_uvlo = 0, main_below_uvlo = 0, main_below_uv7 = 0;
  logic       main_below_uv17 = 0, mode_24v = 0, main_above_ov = 0;
  logic       thr_we = 0, clr_we = 0;
  logic [1:0] thr_wdata = 0;
  logic [3:0] clr_mask = 0;
  logic [1:0] ov_thr_sel;
  logic [3:0] live_status, sticky_event;
  logic       drv_disable;

  int tests = 0, fails = 0;
  int run [4];
  bit mevt [4];
  int mthr;

  always #2.5 clk = ~clk;

  supply_fault_monitor #(.FILT_CYCLES(N)) u_supply_fault_monitor (
    .clk(clk), .rst_n(rst_n),
    .vl_below_uvlo(vl_below_uvlo), .main_below_uvlo(main_below_uvlo),
    .main_below_uv7(main_below_uv7), .main_below_uv17(main_below_uv17),
    .mode_24v(mode_24v), .main_above_ov(main_above_ov),
    .thr_we(thr_we), .thr_wdata(thr_wdata),
    .clr_we(clr_we), .clr_mask(clr_mask),
    .ov_thr_sel(ov_thr_sel), .live_status(live_status),
    .sticky_event(sticky_event), .drv_disable(drv_disable)
  );

  function automatic bit cond(int k);
    case (k)
      0: return vl_below_uvlo;
      1: return main_below_uvlo;
      2: return mode_24v ? main_below_uv17 : main_below_uv7;
      default: return main_above_ov;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 4; k++) begin
        bit c, s;
        c = cond(k);
        if (k == 0) s = c;
        else begin
          run[k] = c ? ((run[k] < N) ? run[k] + 1 : N) : 0;
          s = (run[k] >= N);
        end
        if (clr_we && clr_mask[k]) mevt[k] = 0;
        if (s) mevt[k] = 1;
      end
      if (thr_we) mthr = (thr_wdata == 2'b00) ? 0 : (thr_wdata == 2'b01) ? 1 : 2;
    end
  end

  task automatic chk(string tag, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R2 status bit0", live_status[0], vl_below_uvlo);
    chk("R2 status bit1", live_status[1], main_below_uvlo);
    chk("R3 status bit2", live_status[2], cond(2));
    chk("R2 status bit3", live_status[3], main_above_ov);
    chk("R6 R7 R8 event bit0", sticky_event[0], mevt[0]);
    for (int k = 1; k < 4; k++)
      chk($sformatf("R4 R5 R7 R8 event bit%0d", k), sticky_event[k], mevt[k]);
    chk("R9 threshold", ov_thr_sel, mthr);
    chk("R10 disable", drv_disable, main_above_ov);
  endtask

  task automatic randomize_inputs(int hold_pct, int clr_pct);
    if ($urandom_range(99) >= hold_pct) vl_below_uvlo   = ~vl_below_uvlo;
    if ($urandom_range(99) >= hold_pct) main_below_uvlo = ~main_below_uvlo;
    if ($urandom_range(99) >= hold_pct) main_below_uv7  = ~main_below_uv7;
    if ($urandom_range(99) >= hold_pct) main_below_uv17 = ~main_below_uv17;
    if ($urandom_range(99) >= 97)       mode_24v        = ~mode_24v;
    if ($urandom_range(99) >= hold_pct) main_above_ov   = ~main_above_ov;
    clr_we   = ($urandom_range(99) < clr_pct);
    clr_mask = 4'($urandom_range(15));
    thr_we   = ($urandom_range(99) < 5);
    thr_wdata = 2'($urandom_range(3));
  endtask

  initial begin
    for (int k = 0; k < 4; k++) begin run[k] = 0; mevt[k] = 0; end
    mthr = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset events", sticky_event, 0);
    chk("R1 reset threshold", ov_thr_sel, 0);
    rst_n = 1'b1;
    // R4 R5: bursts of N-1 must not latch, N must latch
    for (int len = N - 1; len <= N; len++) begin
      @(negedge clk);
      main_below_uvlo = 1;
      repeat (len) begin @(negedge clk); compare_all(); end
      main_below_uvlo = 0;
      @(negedge clk); compare_all();
    end
    // R9: every code written in turn
    for (int c = 0; c < 4; c++) begin
      thr_we = 1; thr_wdata = 2'(c);
      @(negedge clk); thr_we = 0; compare_all();
    end
    // R8: clear while OV keeps qualifying
    main_above_ov = 1;
    repeat (N + 2) begin @(negedge clk); compare_all(); end
    clr_we = 1; clr_mask = 4'hF;
    @(negedge clk); compare_all(); clr_we = 0;
    main_above_ov = 0;
    @(negedge clk); compare_all();
    clr_we = 1; clr_mask = 4'hF;
    @(negedge clk); compare_all(); clr_we = 0;
    // random phases: long holds, short glitches, mixed
    for (int ph = 0; ph < 3; ph++) begin
      for (int i = 0; i < 4000; i++) begin
        randomize_inputs(ph == 0 ? 95 : (ph == 1 ? 70 : 88), ph == 2 ? 20 : 4);
        @(negedge clk);
        compare_all();
      end
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule